// File: doc/BRIEF.md
# Microprogram Run and Breakpoint Controller

This block sits between a debug host and a microprogram sequencer and decides, cycle by cycle, whether the sequencer may advance. The host presents one command at a time on a small code bus. The commands are free run, single step, stop, run until a breakpoint, restart from address zero, and cancel a breakpoint run. The sequencer returns its current pipeline field and its internal registers. One bit of the pipeline field marks a microinstruction as a breakpoint.

When execution stops, the block freezes a copy of the sequencer's visible state for the host to read. The copy holds the instruction code, the data field, the program counter, the counter register and every stack entry. The copy is never refreshed while the sequencer runs, so the host reads a consistent picture of the halted machine.

Top module: `ucode_debug_ctrl`

## Requirements
- R1: A run command (code 1) accepted in cycle k drives `adv_en` high in every cycle from k+1 through the cycle in which a stop command (code 3) is presented. `mode` reads 1 while running and 0 once stopped.
- R2: A step command (code 2) accepted while stopped raises `adv_en` for exactly one cycle (k+1), and `mode` stays 0.
- R3: A clear command (code 5) raises `seq_clear` for exactly cycle k+1 and forces `mode` to 0. The sequencer then restarts at address 0.
- R4: A breakpoint-run command (code 4) sets `mode` to 2. The sequencer advances every cycle until a cycle in which bit BP_BIT (default 20) of `seq_field` is high. In that cycle `adv_en` is low, so the flagged microinstruction is not executed, and `mode` returns to 0.
- R5: A breakpoint halt produces exactly one cycle of `bp_hit`, in the cycle after the halt.
- R6: A cancel command (code 6) presented in `mode` 2 returns `mode` to 0, and `adv_en` is low from the next cycle on.
- R7: While `mode` is 2, every code except cancel is ignored. Outside `mode` 2, cancel is ignored.
- R8: The first cycle of a breakpoint run does not check the breakpoint bit. A breakpoint run started while sitting on a flagged microinstruction therefore executes it and goes on.
- R9: A step from a flagged microinstruction executes it and does not report a breakpoint.
- R10: The snapshot is updated only when execution stops. Its new value is visible 2 cycles after a stop, a cancel or a breakpoint halt, and 3 cycles after a step or a clear. The snapshot layout is: instruction code in `seq_field[3:0]`, data field in `seq_field[19:4]`. At all other times the snapshot does not change, including while running.
- R11: During and after reset, `mode` is 0, `adv_en`, `seq_clear` and `bp_hit` are low, and the snapshot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_code | input | 3 | 1 run, 2 step, 3 stop, 4 breakpoint run, 5 clear, 6 cancel |
| seq_field | input | BP_BIT+1 | Sequencer pipeline field: instruction code, data field, breakpoint bit on top |
| cur_pc | input | AW | Sequencer program counter |
| cur_r | input | AW | Sequencer counter register |
| cur_stack | input | DEPTH*AW | Sequencer stack, entry 0 in the low bits |
| adv_en | output | 1 | Sequencer may advance this cycle |
| seq_clear | output | 1 | Synchronous restart request to the sequencer |
| mode | output | 2 | 0 stopped, 1 running, 2 running to breakpoint |
| bp_hit | output | 1 | One-cycle pulse after a breakpoint halt |
| snap_instr | output | IW | Frozen instruction code |
| snap_d | output | BP_BIT-IW | Frozen data field |
| snap_pc | output | AW | Frozen program counter |
| snap_r | output | AW | Frozen counter register |
| snap_stack | output | DEPTH*AW | Frozen stack |

## Verification
Mode and `seq_clear` react one cycle after the command cycle. A breakpoint halt pulls `adv_en` low in the same cycle that the flag is seen. The snapshot lands 2 cycles after a stop, a cancel or a halt, and 3 cycles after a step or a clear, because it must wait until the sequencer has settled.

The bench drives commands on falling edges and samples on falling edges. It waits at least four cycles before it reads the snapshot or the stopped program counter. It derives expected counter values by counting the cycles in which advance was allowed.

// File: rtl/udbg_pkg.sv
package udbg_pkg;

  typedef enum logic [1:0] {
    M_STOP  = 2'd0,
    M_RUN   = 2'd1,
    M_RUNBP = 2'd2
  } mode_e;

  localparam logic [2:0] C_RUN    = 3'd1;
  localparam logic [2:0] C_STEP   = 3'd2;
  localparam logic [2:0] C_IDLE   = 3'd3;
  localparam logic [2:0] C_RUNBP  = 3'd4;
  localparam logic [2:0] C_CLEAR  = 3'd5;
  localparam logic [2:0] C_CANCEL = 3'd6;

  // Halt decision: only in breakpoint mode, never on the first cycle of it.
  function automatic logic halt_on_flag(mode_e m, logic flag, logic first);
    return (m == M_RUNBP) && flag && !first;
  endfunction

endpackage

// File: rtl/udbg_ctrl_fsm.sv
module udbg_ctrl_fsm
  import udbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       bp_flag,
  output logic       adv_en,
  output logic       seq_clear,
  output logic [1:0] mode,
  output logic       bp_hit,
  output logic       cap_now
);

  mode_e mode_q, mode_d;
  logic  step_q, step_d;
  logic  clear_q, clear_d;
  logic  first_q, first_d;
  logic  cap_q, cap_d;
  logic  hit_q, hit_d;

  // named events
  logic bp_evt;
  logic cancel_evt;
  logic normal_acc;

  assign bp_evt     = halt_on_flag(mode_q, bp_flag, first_q);
  assign cancel_evt = cmd_valid && (mode_q == M_RUNBP) && (cmd_code == C_CANCEL) && !bp_evt;
  assign normal_acc = cmd_valid && (mode_q != M_RUNBP);

  assign adv_en = (mode_q == M_RUN) || step_q || ((mode_q == M_RUNBP) && !bp_evt);

  always_comb begin
    mode_d  = mode_q;
    step_d  = 1'b0;
    clear_d = 1'b0;
    first_d = 1'b0;
    hit_d   = 1'b0;
    cap_d   = step_q || clear_q;
    if (bp_evt) begin
      mode_d = M_STOP;
      hit_d  = 1'b1;
      cap_d  = 1'b1;
    end else if (cancel_evt) begin
      mode_d = M_STOP;
      cap_d  = 1'b1;
    end else if (normal_acc) begin
      case (cmd_code)
        C_RUN:   mode_d = M_RUN;
        C_RUNBP: begin
          mode_d  = M_RUNBP;
          first_d = 1'b1;
        end
        C_IDLE: begin
          mode_d = M_STOP;
          cap_d  = 1'b1;
        end
        C_STEP: begin
          if (mode_q == M_STOP && !step_q && !clear_q) step_d = 1'b1;
        end
        C_CLEAR: begin
          mode_d  = M_STOP;
          clear_d = 1'b1;
        end
        default: mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_STOP;
      step_q  <= 1'b0;
      clear_q <= 1'b0;
      first_q <= 1'b0;
      cap_q   <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      step_q  <= step_d;
      clear_q <= clear_d;
      first_q <= first_d;
      cap_q   <= cap_d;
      hit_q   <= hit_d;
    end
  end

  assign seq_clear = clear_q;
  assign mode      = mode_q;
  assign bp_hit    = hit_q;
  assign cap_now   = cap_q;

  a_r1_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && !cmd_valid) |=> (mode_q == M_RUN && adv_en));

  a_r2_step_single: assert property (@(posedge clk) disable iff (!rst_n)
    step_q |=> !step_q);

  a_r3_clear_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    clear_q |-> (!adv_en && mode_q == M_STOP));

  a_r4_bp_halts: assert property (@(posedge clk) disable iff (!rst_n)
    bp_evt |=> (mode_q == M_STOP && !adv_en));

  a_r5_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |=> !hit_q);

  a_r6_cancel_stops: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> (mode_q == M_STOP && !adv_en));

  a_r7_bp_mode_deaf: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUNBP && cmd_valid && cmd_code != C_CANCEL && !bp_evt) |=> (mode_q == M_RUNBP));

endmodule

// File: rtl/udbg_snapshot.sv
module udbg_snapshot #(
  parameter int IW    = 4,
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int DEPTH = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap,
  input  logic [IW-1:0]       in_instr,
  input  logic [DW-1:0]       in_d,
  input  logic [AW-1:0]       in_pc,
  input  logic [AW-1:0]       in_r,
  input  logic [DEPTH*AW-1:0] in_stack,
  output logic [IW-1:0]       out_instr,
  output logic [DW-1:0]       out_d,
  output logic [AW-1:0]       out_pc,
  output logic [AW-1:0]       out_r,
  output logic [DEPTH*AW-1:0] out_stack
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_instr <= '0;
      out_d     <= '0;
      out_pc    <= '0;
      out_r     <= '0;
    end else if (cap) begin
      out_instr <= in_instr;
      out_d     <= in_d;
      out_pc    <= in_pc;
      out_r     <= in_r;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_stk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   out_stack[e*AW +: AW] <= '0;
      else if (cap) out_stack[e*AW +: AW] <= in_stack[e*AW +: AW];
    end
  end

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(out_pc) && $stable(out_d) && $stable(out_stack)));

endmodule

// File: rtl/ucode_debug_ctrl.sv
module ucode_debug_ctrl #(
  parameter int IW     = 4,
  parameter int BP_BIT = 20,
  parameter int AW     = 12,
  parameter int DEPTH  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_code,
  input  logic [BP_BIT:0]      seq_field,
  input  logic [AW-1:0]        cur_pc,
  input  logic [AW-1:0]        cur_r,
  input  logic [DEPTH*AW-1:0]  cur_stack,
  output logic                 adv_en,
  output logic                 seq_clear,
  output logic [1:0]           mode,
  output logic                 bp_hit,
  output logic [IW-1:0]        snap_instr,
  output logic [BP_BIT-IW-1:0] snap_d,
  output logic [AW-1:0]        snap_pc,
  output logic [AW-1:0]        snap_r,
  output logic [DEPTH*AW-1:0]  snap_stack
);

  localparam int DW = BP_BIT - IW;

  logic          bp_flag;
  logic          cap_now;
  logic [IW-1:0] fld_instr;
  logic [DW-1:0] fld_d;

  assign bp_flag   = seq_field[BP_BIT];
  assign fld_instr = seq_field[IW-1:0];
  assign fld_d     = seq_field[BP_BIT-1:IW];

  udbg_ctrl_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .bp_flag   (bp_flag),
    .adv_en    (adv_en),
    .seq_clear (seq_clear),
    .mode      (mode),
    .bp_hit    (bp_hit),
    .cap_now   (cap_now)
  );

  udbg_snapshot #(.IW(IW), .DW(DW), .AW(AW), .DEPTH(DEPTH)) i_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap_now),
    .in_instr  (fld_instr),
    .in_d      (fld_d),
    .in_pc     (cur_pc),
    .in_r      (cur_r),
    .in_stack  (cur_stack),
    .out_instr (snap_instr),
    .out_d     (snap_d),
    .out_pc    (snap_pc),
    .out_r     (snap_r),
    .out_stack (snap_stack)
  );

  a_r11_stop_no_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !$past(cmd_valid) && !bp_hit && !cap_now) |-> !seq_clear || !adv_en);

endmodule

// File: tb/test_ucode_debug_ctrl.sv
module test_ucode_debug_ctrl;

  localparam int IW = 4, BP = 20, AW = 12, DEPTH = 5;
  localparam int DW = BP - IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [BP:0] seq_field;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] cur_r;
  logic [DEPTH*AW-1:0] cur_stack;
  logic adv_en, seq_clear, bp_hit;
  logic [1:0] mode;
  logic [IW-1:0] snap_instr;
  logic [DW-1:0] snap_d;
  logic [AW-1:0] snap_pc, snap_r;
  logic [DEPTH*AW-1:0] snap_stack;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // simple sequencer stand-in
  always_ff @(posedge clk) begin
    if (seq_clear) pc <= '0;
    else if (adv_en) pc <= pc + 1'b1;
  end
  function automatic logic [DW-1:0] dval(logic [AW-1:0] p);
    return {4'h0, p} ^ 16'hA5A5;
  endfunction
  assign seq_field = {(pc == 12'd6 || pc == 12'd40), dval(pc), pc[3:0]};
  assign cur_r = ~pc;
  for (genvar e = 0; e < DEPTH; e++) begin : g_st
    assign cur_stack[e*AW +: AW] = pc + AW'(e + 1);
  end

  ucode_debug_ctrl i_ucode_debug_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .seq_field(seq_field), .cur_pc(pc), .cur_r(cur_r), .cur_stack(cur_stack),
    .adv_en(adv_en), .seq_clear(seq_clear), .mode(mode), .bp_hit(bp_hit),
    .snap_instr(snap_instr), .snap_d(snap_d), .snap_pc(snap_pc), .snap_r(snap_r),
    .snap_stack(snap_stack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
  endtask

  task automatic wait_stop(input int maxc, output int hits);
    hits = 0;
    for (int i = 0; i < maxc && mode != 2'd0; i++) begin
      @(negedge clk);
      if (bp_hit) hits++;
    end
    repeat (3) begin
      @(negedge clk);
      if (bp_hit) hits++;
    end
  endtask

  task automatic chk_snap(input string req, input int exp_pc);
    chk(snap_pc == AW'(exp_pc), req, snap_pc, exp_pc);
    chk(snap_d == dval(AW'(exp_pc)), req, snap_d, dval(AW'(exp_pc)));
    chk(snap_stack[AW-1:0] == AW'(exp_pc + 1), req, snap_stack[AW-1:0], exp_pc + 1);
  endtask

  // cmd(3) gap(8) mode(2) chk_pc(1) pc(12)
  localparam logic [25:0] VT [0:6] = '{
    {3'd2, 8'd4, 2'd0, 1'b1, 12'd1},   // R2 step
    {3'd2, 8'd4, 2'd0, 1'b1, 12'd2},   // R2 step
    {3'd1, 8'd3, 2'd1, 1'b0, 12'd0},   // R1 run
    {3'd3, 8'd4, 2'd0, 1'b1, 12'd6},   // R1 stop after 4 advances
    {3'd6, 8'd4, 2'd0, 1'b1, 12'd6},   // R7 cancel ignored when stopped
    {3'd5, 8'd4, 2'd0, 1'b1, 12'd0},   // R3 clear
    {3'd3, 8'd4, 2'd0, 1'b1, 12'd0}    // R10 stop while stopped
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hits;
    int last_snap;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(mode == 2'd0, "R11 mode", mode, 0);
    chk(!adv_en && !seq_clear && !bp_hit, "R11 outputs", adv_en, 0);
    chk(snap_pc == '0 && snap_stack == '0, "R11 snapshot", snap_pc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    last_snap = 0;

    for (int v = 0; v < 7; v++) begin
      send(VT[v][25:23]);
      repeat (int'(VT[v][22:15])) @(negedge clk);
      chk(mode == VT[v][14:13], "R1/R2/R3/R7 mode", mode, VT[v][14:13]);
      chk(adv_en == (VT[v][14:13] == 2'd1), "R1 adv_en", adv_en, VT[v][14:13] == 2'd1);
      if (VT[v][12]) begin
        chk(pc == VT[v][11:0], "R1/R2/R3 pc", pc, VT[v][11:0]);
        chk_snap("R10 snapshot", VT[v][11:0]);
        last_snap = VT[v][11:0];
      end else begin
        chk(snap_pc == AW'(last_snap), "R10 frozen while running", snap_pc, last_snap);
      end
    end

    // R4 R5 breakpoint run from 0 halts at 6
    send(3'd4);
    chk(mode == 2'd2, "R4 mode", mode, 2);
    wait_stop(100, hits);
    chk(pc == 12'd6, "R4 halt pc", pc, 6);
    chk(hits == 1, "R5 bp_hit pulses", hits, 1);
    chk(!adv_en && mode == 2'd0, "R4 stopped", mode, 0);
    chk_snap("R10 after halt", 6);

    // R8 resume from flagged instruction
    send(3'd4);
    repeat (5) @(negedge clk);
    chk(pc == 12'd11 && mode == 2'd2, "R8 resumed", pc, 11);

    // R7 other codes ignored in breakpoint mode
    send(3'd3); send(3'd1); send(3'd2); send(3'd5);
    chk(mode == 2'd2, "R7 mode kept", mode, 2);
    chk(pc == 12'd15, "R7 still advancing", pc, 15);

    // R6 cancel
    send(3'd6);
    hits = 0;
    repeat (3) begin
      @(negedge clk);
      if (bp_hit) hits++;
    end
    chk(mode == 2'd0 && !adv_en, "R6 cancel stops", mode, 0);
    chk(pc == 12'd16, "R6 pc", pc, 16);
    chk(hits == 0, "R6 no bp_hit", hits, 0);
    chk_snap("R10 after cancel", 16);

    // R3 clear pulse width
    cmd_valid = 1'b1; cmd_code = 3'd5;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 3'd0;
    chk(seq_clear, "R3 clear pulse", seq_clear, 1);
    @(negedge clk);
    chk(!seq_clear, "R3 clear one cycle", seq_clear, 0);
    chk(pc == 12'd0, "R3 restart at 0", pc, 0);

    // R9 step from flagged instruction
    send(3'd4);
    wait_stop(100, hits);
    chk(pc == 12'd6, "R9 setup halt", pc, 6);
    send(3'd2);
    hits = 0;
    repeat (3) begin
      @(negedge clk);
      if (bp_hit) hits++;
    end
    chk(pc == 12'd7 && hits == 0, "R9 step executes flagged", pc, 7);
    chk_snap("R10 after step", 7);

    // R11 reset while running
    send(3'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(mode == 2'd0 && !adv_en, "R11 reset mid-run", mode, 0);
    chk(snap_pc == '0, "R11 snapshot cleared", snap_pc, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule